// File: doc/BRIEF.md
# Run Result Hold Register

This block keeps the final answer of a multi-cycle computation steady, for example while it is shown on a display. The answer stays there until the next run of the computation ends, and the new answer then replaces the old one. A run is framed by a single run-active level that is high for the whole run. The computation drives that level from the opposite clock edge to the one it uses for its data, so the level drops half a cycle after the last data update.

The block compares the run-active level with a registered copy of itself to find the falling transition. It then loads the result bus on the next rising clock edge. At that point the result has been stable for a full cycle. A rising transition or a constant level loads nothing, so the held value does not follow the result bus either during a run or between runs. Reset clears the held value to zero, and reset also clears the registered copy of run-active.

Top module: `result_hold`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `held_out` is 0 and stays 0 until the first run completes.
- R2: At the first rising edge where `run_active` is sampled 0 and was sampled 1 at the previous edge (both edges out of reset), `held_out` takes the value that `result_in` has at that edge. This includes the extreme values 8'h00 and 8'hFF.
- R3: While `run_active` is high, `held_out` does not change, whatever `result_in` does.
- R4: While `run_active` stays low, changes on `result_in` have no effect on `held_out`.
- R5: A rising transition of `run_active` does not load `held_out`.
- R6: A run that is already active when reset is released completes normally, and its falling transition loads the result.
- R7: When reset is active at the edge where a fall would be taken, reset wins: `held_out` becomes 0, and no load happens on the first edge after reset is released.
- R8: Runs separated by a single low cycle of `run_active` are each loaded, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run_active | input | 1 | High for the whole computation run; driven from the falling clock edge |
| result_in | input | W (8) | Output of the computation, updated on rising edges |
| held_out | output | W (8) | Final result of the last completed run |

## Verification
A reset and the load of a finished run can land on the same rising edge. The bench provokes this by dropping `run_active` and asserting `rst_n` at the same falling edge. It then expects `held_out` to read zero at that edge and also at the first edge after release, because a stale registered copy must not produce a late load. A load and the start of the next run can also sit one cycle apart. The back-to-back scenario checks that both results appear in order.

// File: rtl/result_hold_pkg.sv
`timescale 1ns/100ps
// Shared parameters for the run result hold register.
package result_hold_pkg;
    // Default width of the result bus.
    localparam int unsigned RESULT_W = 8;
    // Reset value of the held result.
    localparam logic [RESULT_W-1:0] HELD_RESET = '0;
endpackage

// File: rtl/hold_fall_detect.sv
`timescale 1ns/100ps
// Synchronous falling-transition detector.
// Function: keeps a registered copy of a level and flags the cycle in which
//           the copy is 1 and the live level is 0.
// Assumes:  the level is already synchronous to clk, because it is driven
//           half a cycle away from the sampling edge. Reset clears the copy,
//           so no fall is reported on the first edge after reset.
module hold_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic level_q;

    // Registers the previous sampled value of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    // Flags the high-to-low transition for the current edge.
    always_comb fall = level_q & ~level;
endmodule

// File: rtl/hold_capture_reg.sv
`timescale 1ns/100ps
// Load-enabled holding register.
// Function: takes d when load is high, and otherwise keeps its value.
// Assumes:  load is high for one cycle per completed run.
module hold_capture_reg #(
    parameter int unsigned W = result_hold_pkg::RESULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ZERO = '0;

    // Clears on reset, loads on request, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= ZERO;
        else if (load) q <= d;
    end
endmodule

// File: rtl/result_hold.sv
`timescale 1ns/100ps
// Run result hold register (top).
// Function: shows the final result of the last completed run and replaces it
//           when the next run ends, which is marked by the fall of run_active.
// Assumes:  run_active stays high for the whole run and is driven from the
//           falling clock edge, and result_in is steady from its last update
//           until the load edge.
module result_hold #(
    parameter int unsigned W = result_hold_pkg::RESULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_active,
    input  logic [W-1:0] result_in,
    output logic [W-1:0] held_out
);
    logic run_done;

    // Finds the end of a run.
    hold_fall_detect u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level (run_active),
        .fall  (run_done)
    );

    // Keeps the result of the last completed run.
    hold_capture_reg #(.W(W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (run_done),
        .d     (result_in),
        .q     (held_out)
    );
endmodule

// File: rtl/result_hold_chk.sv
`timescale 1ns/100ps
// Property checker for result_hold; it keeps its own copy of run_active.
module result_hold_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_active,
    input logic [W-1:0] result_in,
    input logic [W-1:0] held_out
);
    logic seen_q;
    logic any_load;
    logic end_now;

    // Checker-side record of run_active and of whether any run has ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            any_load <= 1'b0;
        end else begin
            seen_q   <= run_active;
            any_load <= any_load | (seen_q & ~run_active);
        end
    end

    always_comb end_now = seen_q & ~run_active;

    // R1: reset clears the held value
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> held_out == '0);

    // R1: zero until the first run after reset completes
    a_r1_zero_until_run: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |-> held_out == '0);

    // R2: end of run loads result_in
    a_r2_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        end_now |=> held_out == $past(result_in));

    // R3/R4/R5: without a run end, the held value does not move
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !end_now |=> $stable(held_out));
endmodule

bind result_hold result_hold_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_active (run_active),
    .result_in  (result_in),
    .held_out   (held_out)
);

// File: tb/sim_result_hold.sv
`timescale 1ns/100ps
module sim_result_hold;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_active = 1'b0;
    logic [W-1:0] result_in = '0;
    logic [W-1:0] held_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    result_hold #(.W(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_active (run_active),
        .result_in  (result_in),
        .held_out   (held_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: held_out=%02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] val(input logic [W-1:0] seed, input int i);
        return seed + W'(i * 37);
    endfunction

    // A run of n updates; checks R5 and R3 along the way and R2 at the end.
    task automatic do_run(input int n, input logic [W-1:0] seed, input logic [W-1:0] prev);
        @(negedge clk); run_active = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #0.5 result_in = val(seed, i);
            #0.5;
            if (i == 0) check("R5 rise no load", held_out, prev);
            else        check("R3 stable in run", held_out, prev);
        end
        @(negedge clk); run_active = 1'b0;
        @(posedge clk); #1 check("R2 load on fall", held_out, val(seed, n - 1));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 check("R1 reset value", held_out, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #0.5 result_in = 8'h11 * i[7:0] + 8'h07;
            #0.5 check("R1 zero before first run", held_out, 8'h00);
        end
    endtask

    task automatic t_idle(input logic [W-1:0] exp);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #0.5 result_in = ~result_in ^ 8'(i);
            #0.5 check("R4 idle ignored", held_out, exp);
        end
    endtask

    task automatic t_back_to_back;
        do_run(3, 8'h20, 8'hFF);
        do_run(2, 8'h90, val(8'h20, 2));
        check("R8 second run loaded", held_out, val(8'h90, 1));
    endtask

    task automatic t_reset_on_fall;
        @(negedge clk); run_active = 1'b1;
        @(posedge clk); #0.5 result_in = 8'h3C;
        @(negedge clk); run_active = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1 check("R7 reset beats load", held_out, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 check("R7 no late load", held_out, 8'h00);
        @(posedge clk); #1 check("R7 still zero", held_out, 8'h00);
    endtask

    task automatic t_run_across_reset;
        @(negedge clk); rst_n = 1'b0; run_active = 1'b1; result_in = 8'h5A;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #0.5 result_in = 8'h6B;
        #0.5 check("R6 zero during run", held_out, 8'h00);
        @(negedge clk); run_active = 1'b0;
        @(posedge clk); #1 check("R6 run across reset loads", held_out, 8'h6B);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        do_run(3, 8'hA5, 8'h00);
        t_idle(val(8'hA5, 2));
        do_run(1, 8'hFF, val(8'hA5, 2));
        t_back_to_back;
        do_run(1, 8'h00, val(8'h90, 1));
        t_idle(8'h00);
        t_reset_on_fall;
        t_run_across_reset;
        do_run(4, 8'h13, 8'h6B);
        repeat (3) @(posedge clk);
        finish_run;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, got %0d expected 0 pending", 1);
        finish_run;
    end
endmodule